// File: doc/BRIEF.md
# SD SPI-mode initialization sequencer

This block is the control state machine that takes a freshly powered SD card into SPI mode and leaves it ready for block transfers. It does not shift bytes itself. It hands work to two neighbours through request/acknowledge pairs. A fill engine clocks out one all-ones byte with chip select high for each request. A command engine sends one command frame with the given index and 32-bit argument, then returns the R1 status byte or a timeout flag.

A start pulse launches the sequence. The sequence is: warm-up bytes, the reset command, and the interface-condition probe. The probe reply chooses a legacy polling loop or a high-capacity polling loop. Each loop is bounded by an attempt counter, so an unresponsive card ends in a fail state instead of hanging. The high-capacity loop waits a programmable number of system-clock ticks before each attempt. After a loop succeeds, a block-length command is sent. If it is accepted, the sequencer selects the fast SPI clock and reports ready, together with the card generation and the address multiplier that later transfers must use.

State names, in order: `ST_IDLE`, `ST_FILL_REQ`/`ST_FILL_WAIT`, `ST_RST_REQ`/`ST_RST_WAIT`, `ST_PROBE_REQ`/`ST_PROBE_WAIT`, legacy loop `ST_L_APP_REQ`/`ST_L_APP_WAIT`/`ST_L_OP_REQ`/`ST_L_OP_WAIT`, high-capacity loop `ST_H_PAUSE`/`ST_H_OCR_REQ`/`ST_H_OCR_WAIT`/`ST_H_APP_REQ`/`ST_H_APP_WAIT`/`ST_H_OP_REQ`/`ST_H_OP_WAIT`/`ST_H_FIN_REQ`/`ST_H_FIN_WAIT`, then `ST_BLK_REQ`/`ST_BLK_WAIT`, and the terminal states `ST_READY` and `ST_FAIL`.

Transitions:
- A `*_REQ` state always moves to its `*_WAIT` state after one cycle.
- A `*_WAIT` state leaves only when its done input is high.
- `ST_PROBE_WAIT` moves to `ST_H_PAUSE` on status 0x01 and to `ST_L_APP_REQ` on status 0x05. On any other status, or on a timeout, it moves to `ST_FAIL`.
- A failed operating-condition poll goes back to the start of its loop: `ST_L_APP_REQ` for the legacy loop and `ST_H_PAUSE` for the high-capacity loop. On the last allowed attempt it goes to `ST_FAIL` instead.
- `ST_READY` and `ST_FAIL` return to `ST_FILL_REQ` on start.

Top module: `sdspi_init_seq`

## Requirements
- R1: After reset the block issues no fill or command request, and ready, fail, fast clock, no-card and card type are all 0 (card type encoding: 0 none, 1 legacy, 2 high-capacity).
- R2: After start, exactly FILL_BYTES fill requests complete before the first command, which is index 0 with argument 0.
- R3: When the index-0 reply is not exactly 0x01, or it times out, no_card_o is set and the sequence still continues with index 8.
- R4: Index 8 is sent with argument 0x000001AA. A status of 0x01 selects the high-capacity loop and 0x05 selects the legacy loop. Any other status, or a timeout, ends in fail with no further command.
- R5: The legacy loop repeats index 55 (argument 0) then index 41 (argument 0) until the index-41 status is 0x00. It then reports card type 1 and address multiplier 512.
- R6: Each high-capacity attempt begins with a pause, after which the start for index 58 comes exactly WAIT_TICKS+1 cycles after the cycle in which the previous reply's done was seen. The attempt then sends indices 58, 55 and 41 (argument 0x40000000). On success one more index 58 follows, and the block reports card type 2 and address multiplier 1.
- R7: Each loop allows at most MAX_TRIES index-41 attempts. If all of them fail, the block ends in fail with card type 0.
- R8: Index 16 is sent with argument 512 after a successful loop. Status 0x00 leads to ready with the fast clock selected. Any other status, or a timeout, leads to fail.
- R9: A timeout flag makes a reply unsuccessful even if the status byte reads 0x00.
- R10: Ready and fail are never both high. Each holds with no new request until the next start, and a start during a running sequence is ignored.
- R11: A command start is a one-cycle pulse, and the index and argument stay stable until done returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin (or restart from ready/fail) the sequence |
| fill_start_o | output | 1 | Request one all-ones byte with chip select high |
| fill_done_i | input | 1 | Fill byte finished |
| cmd_start_o | output | 1 | One-cycle command request |
| cmd_idx_o | output | 6 | Command index |
| cmd_arg_o | output | 32 | Command argument |
| cmd_done_i | input | 1 | Command engine finished, reply valid |
| cmd_r1_i | input | 8 | R1 status byte |
| cmd_tmo_i | input | 1 | Command engine saw no reply |
| fast_clk_o | output | 1 | 1 selects the fast SPI rate, 0 the slow rate |
| ready_o | output | 1 | Card initialized |
| fail_o | output | 1 | Initialization failed |
| no_card_o | output | 1 | Reset command reply was not the idle status |
| card_type_o | output | 2 | 0 none, 1 legacy, 2 high-capacity |
| addr_mult_o | output | MULT_W | Block-number multiplier for later transfers |

## Verification
All results are registered on the same clock edge that consumes the final done pulse, so ready, fail, card type, multiplier and fast clock are due one edge after the last reply. The bench samples them at the falling edge that follows. The command engine model raises done two falling edges after it sees a start, and it records each start at the falling edge where it appears. This lets the pause length be checked as an exact difference of WAIT_TICKS+1 cycles. The trace of index/argument pairs is compared in full with a list that bench functions build from the scenario.

// File: rtl/sdi_pkg.sv
package sdi_pkg;

    typedef enum logic [4:0] {
        ST_IDLE,
        ST_FILL_REQ,
        ST_FILL_WAIT,
        ST_RST_REQ,
        ST_RST_WAIT,
        ST_PROBE_REQ,
        ST_PROBE_WAIT,
        ST_L_APP_REQ,
        ST_L_APP_WAIT,
        ST_L_OP_REQ,
        ST_L_OP_WAIT,
        ST_H_PAUSE,
        ST_H_OCR_REQ,
        ST_H_OCR_WAIT,
        ST_H_APP_REQ,
        ST_H_APP_WAIT,
        ST_H_OP_REQ,
        ST_H_OP_WAIT,
        ST_H_FIN_REQ,
        ST_H_FIN_WAIT,
        ST_BLK_REQ,
        ST_BLK_WAIT,
        ST_READY,
        ST_FAIL
    } sdi_state_e;

    typedef enum logic [1:0] {
        KIND_NONE   = 2'd0,
        KIND_LEGACY = 2'd1,
        KIND_HIGH   = 2'd2
    } sdi_kind_e;

    localparam logic [5:0]  IX_RESET    = 6'd0;
    localparam logic [5:0]  IX_PROBE    = 6'd8;
    localparam logic [5:0]  IX_BLKLEN   = 6'd16;
    localparam logic [5:0]  IX_OPCOND   = 6'd41;
    localparam logic [5:0]  IX_APPNEXT  = 6'd55;
    localparam logic [5:0]  IX_OCR      = 6'd58;

    localparam logic [31:0] ARG_ZERO    = 32'h0000_0000;
    localparam logic [31:0] ARG_PROBE   = 32'h0000_01AA;
    localparam logic [31:0] ARG_HCS     = 32'h4000_0000;
    localparam logic [31:0] ARG_BLK512  = 32'd512;

    localparam logic [7:0]  ST1_IDLE    = 8'h01;
    localparam logic [7:0]  ST1_OLDCARD = 8'h05;
    localparam logic [7:0]  ST1_CLEAR   = 8'h00;

endpackage

// File: rtl/sdi_count.sv
module sdi_count #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_last
);
    localparam int W = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign at_last = (cnt == W'(LIMIT - 1));

endmodule

// File: rtl/sdi_cmd_sel.sv
module sdi_cmd_sel
    import sdi_pkg::*;
(
    input  sdi_state_e  st,
    output logic        req,
    output logic [5:0]  idx,
    output logic [31:0] arg
);
    always_comb begin
        req = 1'b0;
        idx = IX_RESET;
        arg = ARG_ZERO;
        case (st)
            ST_RST_REQ:    begin req = 1'b1; idx = IX_RESET; end
            ST_RST_WAIT:   begin idx = IX_RESET; end
            ST_PROBE_REQ:  begin req = 1'b1; idx = IX_PROBE; arg = ARG_PROBE; end
            ST_PROBE_WAIT: begin idx = IX_PROBE; arg = ARG_PROBE; end
            ST_L_APP_REQ:  begin req = 1'b1; idx = IX_APPNEXT; end
            ST_L_APP_WAIT: begin idx = IX_APPNEXT; end
            ST_L_OP_REQ:   begin req = 1'b1; idx = IX_OPCOND; end
            ST_L_OP_WAIT:  begin idx = IX_OPCOND; end
            ST_H_OCR_REQ:  begin req = 1'b1; idx = IX_OCR; end
            ST_H_OCR_WAIT: begin idx = IX_OCR; end
            ST_H_APP_REQ:  begin req = 1'b1; idx = IX_APPNEXT; end
            ST_H_APP_WAIT: begin idx = IX_APPNEXT; end
            ST_H_OP_REQ:   begin req = 1'b1; idx = IX_OPCOND; arg = ARG_HCS; end
            ST_H_OP_WAIT:  begin idx = IX_OPCOND; arg = ARG_HCS; end
            ST_H_FIN_REQ:  begin req = 1'b1; idx = IX_OCR; end
            ST_H_FIN_WAIT: begin idx = IX_OCR; end
            ST_BLK_REQ:    begin req = 1'b1; idx = IX_BLKLEN; arg = ARG_BLK512; end
            ST_BLK_WAIT:   begin idx = IX_BLKLEN; arg = ARG_BLK512; end
            default:       begin req = 1'b0; end
        endcase
    end

endmodule

// File: rtl/sdspi_init_seq.sv
module sdspi_init_seq
    import sdi_pkg::*;
#(
    parameter int FILL_BYTES = 16,
    parameter int MAX_TRIES  = 5000,
    parameter int WAIT_TICKS = 2500000,
    parameter int MULT_W     = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic              fill_start_o,
    input  logic              fill_done_i,
    output logic              cmd_start_o,
    output logic [5:0]        cmd_idx_o,
    output logic [31:0]       cmd_arg_o,
    input  logic              cmd_done_i,
    input  logic [7:0]        cmd_r1_i,
    input  logic              cmd_tmo_i,
    output logic              fast_clk_o,
    output logic              ready_o,
    output logic              fail_o,
    output logic              no_card_o,
    output logic [1:0]        card_type_o,
    output logic [MULT_W-1:0] addr_mult_o
);
    localparam logic [MULT_W-1:0] MULT_BYTE  = MULT_W'(512);
    localparam logic [MULT_W-1:0] MULT_BLOCK = MULT_W'(1);

    sdi_state_e state, nxt;

    logic fill_last, try_last, pause_last;
    logic at_rest;
    logic rsp_good, rsp_idle, rsp_old;
    logic op_fail;

    // Reply classification: a timeout always spoils the reply (R9)
    assign rsp_good = cmd_done_i && !cmd_tmo_i && (cmd_r1_i == ST1_CLEAR);
    assign rsp_idle = cmd_done_i && !cmd_tmo_i && (cmd_r1_i == ST1_IDLE);
    assign rsp_old  = cmd_done_i && !cmd_tmo_i && (cmd_r1_i == ST1_OLDCARD);
    assign op_fail  = ((state == ST_L_OP_WAIT) || (state == ST_H_OP_WAIT))
                      && cmd_done_i && !rsp_good;
    assign at_rest  = (state == ST_IDLE) || (state == ST_READY) || (state == ST_FAIL);

    // Warm-up byte counter (R2)
    sdi_count #(.LIMIT(FILL_BYTES)) u_fill_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (at_rest),
        .inc     ((state == ST_FILL_WAIT) && fill_done_i),
        .at_last (fill_last)
    );

    // Operating-condition attempt counter (R7)
    sdi_count #(.LIMIT(MAX_TRIES)) u_try_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (state == ST_PROBE_WAIT),
        .inc     (op_fail),
        .at_last (try_last)
    );

    // Pause timer ahead of each high-capacity attempt (R6)
    sdi_count #(.LIMIT(WAIT_TICKS)) u_pause_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (state != ST_H_PAUSE),
        .inc     (state == ST_H_PAUSE),
        .at_last (pause_last)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE, ST_READY, ST_FAIL: begin
                if (start_i) nxt = ST_FILL_REQ;
            end
            ST_FILL_REQ:  nxt = ST_FILL_WAIT;
            ST_FILL_WAIT: begin
                if (fill_done_i) nxt = fill_last ? ST_RST_REQ : ST_FILL_REQ;
            end
            ST_RST_REQ:   nxt = ST_RST_WAIT;
            ST_RST_WAIT: begin
                if (cmd_done_i) nxt = ST_PROBE_REQ;
            end
            ST_PROBE_REQ: nxt = ST_PROBE_WAIT;
            ST_PROBE_WAIT: begin
                if (cmd_done_i) begin
                    if (rsp_idle)     nxt = ST_H_PAUSE;
                    else if (rsp_old) nxt = ST_L_APP_REQ;
                    else              nxt = ST_FAIL;
                end
            end
            ST_L_APP_REQ: nxt = ST_L_APP_WAIT;
            ST_L_APP_WAIT: begin
                if (cmd_done_i) nxt = ST_L_OP_REQ;
            end
            ST_L_OP_REQ:  nxt = ST_L_OP_WAIT;
            ST_L_OP_WAIT: begin
                if (cmd_done_i) begin
                    if (rsp_good)      nxt = ST_BLK_REQ;
                    else if (try_last) nxt = ST_FAIL;
                    else               nxt = ST_L_APP_REQ;
                end
            end
            ST_H_PAUSE: begin
                if (pause_last) nxt = ST_H_OCR_REQ;
            end
            ST_H_OCR_REQ: nxt = ST_H_OCR_WAIT;
            ST_H_OCR_WAIT: begin
                if (cmd_done_i) nxt = ST_H_APP_REQ;
            end
            ST_H_APP_REQ: nxt = ST_H_APP_WAIT;
            ST_H_APP_WAIT: begin
                if (cmd_done_i) nxt = ST_H_OP_REQ;
            end
            ST_H_OP_REQ:  nxt = ST_H_OP_WAIT;
            ST_H_OP_WAIT: begin
                if (cmd_done_i) begin
                    if (rsp_good)      nxt = ST_H_FIN_REQ;
                    else if (try_last) nxt = ST_FAIL;
                    else               nxt = ST_H_PAUSE;
                end
            end
            ST_H_FIN_REQ: nxt = ST_H_FIN_WAIT;
            ST_H_FIN_WAIT: begin
                if (cmd_done_i) nxt = ST_BLK_REQ;
            end
            ST_BLK_REQ:   nxt = ST_BLK_WAIT;
            ST_BLK_WAIT: begin
                if (cmd_done_i) nxt = rsp_good ? ST_READY : ST_FAIL;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // Command request decode
    sdi_cmd_sel u_cmd_sel (
        .st  (state),
        .req (cmd_start_o),
        .idx (cmd_idx_o),
        .arg (cmd_arg_o)
    );

    assign fill_start_o = (state == ST_FILL_REQ);
    assign ready_o      = (state == ST_READY);
    assign fail_o       = (state == ST_FAIL);

    // Result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fast_clk_o  <= 1'b0;
            no_card_o   <= 1'b0;
            card_type_o <= KIND_NONE;
            addr_mult_o <= '0;
        end else if (at_rest && start_i) begin
            fast_clk_o  <= 1'b0;
            no_card_o   <= 1'b0;
            card_type_o <= KIND_NONE;
            addr_mult_o <= '0;
        end else begin
            if ((state == ST_RST_WAIT) && cmd_done_i && !rsp_idle) begin
                no_card_o <= 1'b1;
            end
            if ((state == ST_L_OP_WAIT) && rsp_good) begin
                card_type_o <= KIND_LEGACY;
                addr_mult_o <= MULT_BYTE;
            end
            if ((state == ST_H_OP_WAIT) && rsp_good) begin
                card_type_o <= KIND_HIGH;
                addr_mult_o <= MULT_BLOCK;
            end
            if ((state == ST_BLK_WAIT) && rsp_good) begin
                fast_clk_o <= 1'b1;
            end
            if ((state != ST_FAIL) && (nxt == ST_FAIL)) begin
                card_type_o <= KIND_NONE;
                addr_mult_o <= '0;
            end
        end
    end

endmodule

// File: rtl/sdspi_init_seq_chk.sv
module sdspi_init_seq_chk #(
    parameter int MULT_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              fill_start_o,
    input logic              cmd_start_o,
    input logic [5:0]        cmd_idx_o,
    input logic [31:0]       cmd_arg_o,
    input logic              fast_clk_o,
    input logic              ready_o,
    input logic              fail_o,
    input logic [1:0]        card_type_o,
    input logic [MULT_W-1:0] addr_mult_o
);
    AST_READY_FAIL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ready_o && fail_o)); // R10

    AST_READY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && !start_i) |=> ready_o); // R10

    AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_o && !start_i) |=> fail_o); // R10

    AST_QUIET_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o || fail_o) |-> (!cmd_start_o && !fill_start_o)); // R10

    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start_o |=> !cmd_start_o); // R11

    AST_CMD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start_o |=> ($stable(cmd_idx_o) && $stable(cmd_arg_o))); // R11

    AST_FAST_ONLY_READY: assert property (@(posedge clk) disable iff (!rst_n)
        fast_clk_o |-> ready_o); // R8

    AST_READY_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> ((card_type_o == 2'd1 && addr_mult_o == MULT_W'(512)) ||
                     (card_type_o == 2'd2 && addr_mult_o == MULT_W'(1)))); // R5

    AST_FAIL_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |-> (card_type_o == 2'd0)); // R7

endmodule

bind sdspi_init_seq sdspi_init_seq_chk #(.MULT_W(MULT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .fill_start_o (fill_start_o),
    .cmd_start_o  (cmd_start_o),
    .cmd_idx_o    (cmd_idx_o),
    .cmd_arg_o    (cmd_arg_o),
    .fast_clk_o   (fast_clk_o),
    .ready_o      (ready_o),
    .fail_o       (fail_o),
    .card_type_o  (card_type_o),
    .addr_mult_o  (addr_mult_o)
);

// File: tb/sdspi_init_seq_bench.sv
module sdspi_init_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int FILL  = 16;
    localparam int TRIES = 6;
    localparam int WAITT = 20;
    localparam int MW    = 10;
    localparam int LAT   = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          fill_done_i = 1'b0;
    logic          cmd_done_i = 1'b0;
    logic          cmd_tmo_i = 1'b0;
    logic [7:0]    cmd_r1_i = 8'h00;
    logic          fill_start_o, cmd_start_o, fast_clk_o, ready_o, fail_o, no_card_o;
    logic [5:0]    cmd_idx_o;
    logic [31:0]   cmd_arg_o;
    logic [1:0]    card_type_o;
    logic [MW-1:0] addr_mult_o;

    sdspi_init_seq #(.FILL_BYTES(FILL), .MAX_TRIES(TRIES), .WAIT_TICKS(WAITT), .MULT_W(MW))
    u_sdspi_init_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .fill_start_o(fill_start_o), .fill_done_i(fill_done_i),
        .cmd_start_o(cmd_start_o), .cmd_idx_o(cmd_idx_o), .cmd_arg_o(cmd_arg_o),
        .cmd_done_i(cmd_done_i), .cmd_r1_i(cmd_r1_i), .cmd_tmo_i(cmd_tmo_i),
        .fast_clk_o(fast_clk_o), .ready_o(ready_o), .fail_o(fail_o),
        .no_card_o(no_card_o), .card_type_o(card_type_o), .addr_mult_o(addr_mult_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int errs = 0;
    int checks = 0;

    // Scenario knobs seen by the card model
    logic [7:0] s_c0, s_c8, s_c16;
    bit         s_c8tmo, s_tmo41, s_c16tmo;
    int         s_okafter;

    logic [5:0]  tr_idx[$];
    logic [31:0] tr_arg[$];
    int fills, a41, t_c8done, t_58first, hold_bad;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Fill engine and command engine model
    initial begin
        logic [5:0]  ix;
        logic [31:0] ag;
        logic [7:0]  r;
        bit          tm;
        forever begin
            @(negedge clk);
            cmd_done_i = 1'b0; cmd_tmo_i = 1'b0; fill_done_i = 1'b0;
            if (fill_start_o) begin
                fills++;
                repeat (LAT-1) @(negedge clk);
                fill_done_i = 1'b1;
            end else if (cmd_start_o) begin
                ix = cmd_idx_o; ag = cmd_arg_o;
                tr_idx.push_back(ix); tr_arg.push_back(ag);
                if (ix == 6'd58 && t_58first < 0) t_58first = cyc;
                tm = 1'b0;
                case (ix)
                    6'd0:  r = s_c0;
                    6'd8:  begin r = s_c8; tm = s_c8tmo; end
                    6'd55: r = 8'h01;
                    6'd58: r = 8'h00;
                    6'd41: begin
                        r  = (a41 >= s_okafter) ? 8'h00 : 8'h01;
                        tm = s_tmo41 && (a41 == 0);
                        a41++;
                    end
                    6'd16: begin r = s_c16; tm = s_c16tmo; end
                    default: r = 8'h04;
                endcase
                repeat (LAT-1) @(negedge clk);
                if (cmd_idx_o != ix || cmd_arg_o != ag) hold_bad++;
                cmd_r1_i = r; cmd_tmo_i = tm; cmd_done_i = 1'b1;
                if (ix == 6'd8) t_c8done = cyc;
            end
        end
    end

    task automatic push_exp(ref logic [5:0] qi[$], ref logic [31:0] qa[$], input logic [5:0] i, input logic [31:0] a);
        qi.push_back(i); qa.push_back(a);
    endtask

    task automatic run(input logic [7:0] c0, input logic [7:0] c8, input bit c8tmo, input int okafter,
                       input bit tmo41, input logic [7:0] c16, input bit c16tmo, input bit poke, input string nm);
        logic [5:0]  ei[$];
        logic [31:0] ea[$];
        bit v1, v2, okl, rdy, same;
        int guard;
        string tag;
        s_c0 = c0; s_c8 = c8; s_c8tmo = c8tmo; s_okafter = okafter;
        s_tmo41 = tmo41; s_c16 = c16; s_c16tmo = c16tmo;
        tr_idx.delete(); tr_arg.delete();
        fills = 0; a41 = 0; t_58first = -1; t_c8done = -1; hold_bad = 0;

        // Expected trace from the requirements
        push_exp(ei, ea, 6'd0, 32'd0);
        push_exp(ei, ea, 6'd8, 32'h1AA);
        v2 = !c8tmo && c8 == 8'h01;
        v1 = !c8tmo && c8 == 8'h05;
        okl = 1'b0;
        if (v1 || v2) begin
            for (int a = 0; a < TRIES && !okl; a++) begin
                if (v2) push_exp(ei, ea, 6'd58, 32'd0);
                push_exp(ei, ea, 6'd55, 32'd0);
                push_exp(ei, ea, 6'd41, v2 ? 32'h4000_0000 : 32'd0);
                if (a >= okafter && !(tmo41 && a == 0)) okl = 1'b1;
            end
        end
        if (okl && v2) push_exp(ei, ea, 6'd58, 32'd0);
        if (okl) push_exp(ei, ea, 6'd16, 32'd512);
        rdy = okl && c16 == 8'h00 && !c16tmo;
        tag = !(v1 || v2) ? "R4" : (!okl ? "R7" : "R8");

        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        if (poke) begin
            repeat (30) @(negedge clk);
            start_i = 1'b1;
            @(negedge clk); start_i = 1'b0;
        end
        guard = 0;
        while (!(ready_o || fail_o) && guard < 20000) begin
            @(negedge clk); guard++;
        end

        chk(fills == FILL, "R2", {nm, " fill count"}, fills, FILL);
        same = (tr_idx.size() == ei.size());
        for (int k = 0; k < ei.size() && same; k++)
            if (tr_idx[k] != ei[k] || tr_arg[k] != ea[k]) same = 1'b0;
        chk(same, v1 ? "R5" : (v2 ? "R6" : "R4"), {nm, " command trace length"}, tr_idx.size(), ei.size());
        if (tmo41) chk(same, "R9", {nm, " timeout with clear status"}, a41, ei.size());
        chk(ready_o == rdy && fail_o == !rdy, tag, {nm, " ready"}, ready_o, rdy);
        chk(card_type_o == (rdy ? (v1 ? 2'd1 : 2'd2) : 2'd0), v1 ? "R5" : "R6", {nm, " card type"},
            card_type_o, rdy ? (v1 ? 1 : 2) : 0);
        if (rdy) chk(addr_mult_o == (v1 ? MW'(512) : MW'(1)), v1 ? "R5" : "R6", {nm, " multiplier"},
                     addr_mult_o, v1 ? 512 : 1);
        chk(fast_clk_o == rdy, "R8", {nm, " fast clock"}, fast_clk_o, rdy);
        chk(no_card_o == (c0 != 8'h01), "R3", {nm, " no-card flag"}, no_card_o, c0 != 8'h01);
        if (v2) chk(t_58first - t_c8done == WAITT + 1, "R6", {nm, " pause length"},
                    t_58first - t_c8done, WAITT + 1);
        chk(hold_bad == 0, "R11", {nm, " index/argument held"}, hold_bad, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        int n0, f0;
        logic [7:0] rc0, rc8, rc16;
        int r;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!cmd_start_o && !fill_start_o, "R1", "no request after reset", cmd_start_o, 0);
        chk(!ready_o && !fail_o && !fast_clk_o, "R1", "status after reset", {ready_o, fail_o, fast_clk_o}, 0);
        chk(card_type_o == 2'd0 && !no_card_o, "R1", "type after reset", card_type_o, 0);

        // Directed corner cases
        run(8'h01, 8'h05, 0, 2, 0, 8'h00, 0, 0, "legacy ok");
        run(8'h01, 8'h01, 0, 0, 0, 8'h00, 0, 1, "high ok with busy start");
        n0 = tr_idx.size(); f0 = fills;
        repeat (25) @(negedge clk);
        chk(ready_o && !fail_o, "R10", "ready held", ready_o, 1);
        chk(tr_idx.size() == n0 && fills == f0, "R10", "quiet while ready", tr_idx.size(), n0);
        run(8'h00, 8'h01, 0, 3, 0, 8'h00, 0, 0, "no card then high");
        run(8'h01, 8'h00, 0, 0, 0, 8'h00, 0, 0, "probe bad status");
        run(8'h01, 8'h01, 1, 0, 0, 8'h00, 0, 0, "probe timeout");
        run(8'h01, 8'h05, 0, 99, 0, 8'h00, 0, 0, "legacy exhausted");
        run(8'h01, 8'h01, 0, 99, 0, 8'h00, 0, 0, "high exhausted");
        n0 = tr_idx.size();
        repeat (25) @(negedge clk);
        chk(fail_o && !ready_o && tr_idx.size() == n0, "R10", "fail held", fail_o, 1);
        run(8'h01, 8'h05, 0, TRIES-1, 0, 8'h00, 0, 0, "legacy last try");
        run(8'h01, 8'h01, 0, 0, 0, 8'h04, 0, 0, "block length rejected");
        run(8'h01, 8'h05, 0, 0, 0, 8'h00, 1, 0, "block length timeout");
        run(8'h01, 8'h01, 0, 0, 1, 8'h00, 0, 0, "op timeout high");
        run(8'h01, 8'h05, 0, 0, 1, 8'h00, 0, 0, "op timeout legacy");

        // Constrained random scenarios
        for (int i = 0; i < 10; i++) begin
            rc0 = ($urandom % 4 == 0) ? 8'($urandom) : 8'h01;
            r = $urandom % 5;
            rc8 = (r < 2) ? 8'h01 : ((r < 4) ? 8'h05 : 8'($urandom % 128));
            rc16 = ($urandom % 5 == 0) ? 8'h40 : 8'h00;
            run(rc0, rc8, 0, $urandom % (TRIES + 2), 0, rc16, 0, 0, "random");
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule